// File: doc/BRIEF.md
# Latching Edge-Capture Interrupt Register

This block watches a group of asynchronous digital inputs, 16 by default. For each input it keeps a sticky history bit. The bit records the first low-to-high change seen on that input since the last system or feature reset. Each input first passes through a two-stage synchroniser, and rising edges are detected on the synchronised level. The current synchronised levels are also driven out directly, with no latching.

Software drives a two-bit command code. A plain read returns the history and leaves it intact. A clearing read returns the history and empties it at the end of the same cycle. An edge that lands in that same cycle is kept and is not lost. An arm command moves the group from recording-only operation into interrupt operation.

A small state machine governs the interrupt. It has three states:
- `ST_IDLE`: unarmed.
- `ST_ARMED`: armed, nothing pending.
- `ST_POSTED`: interrupt request asserted.

It makes these transitions:
- `ST_IDLE` to `ST_ARMED` on an arm command.
- `ST_ARMED` to `ST_POSTED` on any detected rising edge.
- `ST_POSTED` to `ST_ARMED` on a clearing read with no coincident edge.
- `ST_POSTED` stays in `ST_POSTED` on a clearing read that coincides with an edge.
- Any state to `ST_IDLE` on a feature reset.

Top module: `edge_irq_latch`

## Requirements
- R1: After system reset (`rst_n` low), `hist_rd_data` is 0, `rd_valid` is 0, `irq` is 0 and the group is unarmed.
- R2: `live_lvl` equals the input levels delayed by two clock edges through the synchroniser and is never latched.
- R3: A history bit sets on the first synchronised rising edge of its input, one edge after the edge is detected. Later rises and any fall leave it unchanged until a clear.
- R4: Code 2'b01 (plain read) makes `rd_valid` 1 on the next cycle, with `hist_rd_data` equal to the history in the command cycle. The history is left unchanged. Code 2'b00 does nothing.
- R5: Code 2'b10 (clearing read) returns the history as it stood before the clear, with the same timing as R4, and empties the history.
- R6: A rising edge detected in the same cycle as a clearing read is present in the history afterwards.
- R7: Code 2'b11 (arm) puts an unarmed group into interrupt mode and has no effect when already armed. An edge is only counted for an interrupt when the group is armed in the cycle the edge is detected. `irq` rises one edge after such an edge.
- R8: `irq` is a level that stays high until a clearing read. A plain read or an arm command does not drop it. After the clearing read the group stays armed, and the next edge raises `irq` again.
- R9: A clearing read that coincides with a detected edge while `irq` is high leaves `irq` high.
- R10: `feat_rst` high at a clock edge clears the history, `hist_rd_data` and `rd_valid`, disarms the group and drops `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| feat_rst | input | 1 | Synchronous feature reset, active high |
| din | input | WIDTH | Asynchronous input group |
| cmd_op | input | 2 | Command code: 00 none, 01 read, 10 clearing read, 11 arm |
| hist_rd_data | output | WIDTH | History value returned by the last read |
| rd_valid | output | 1 | High for one cycle after a read command |
| live_lvl | output | WIDTH | Synchronised, non-latched input levels |
| irq | output | 1 | Interrupt request level |

## Verification
The most likely internal faults each show up at the ports within a few cycles:
- A history bit stuck or wrongly cleared appears in the next read's returned value.
- A state machine that leaves `ST_POSTED` early drops `irq` on the cycle after a plain read.
- A machine that never re-arms keeps `irq` low on the third edge after a fresh input rise.
- A clear that overrides a coincident edge shows up as a missing bit in the read that follows the clearing read.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_READ  = 2'b01,
        OP_RDCLR = 2'b10,
        OP_ARM   = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_ARMED  = 2'b01,
        ST_POSTED = 2'b10
    } irq_state_e;

endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [W-1:0] stg [SYNC_STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
            prev_q <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
            prev_q <= stg[LAST];
        end
    end

    assign lvl  = stg[LAST];
    assign rise = stg[LAST] & ~prev_q;

endmodule

// File: rtl/edge_irq_hist.sv
module edge_irq_hist #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         feat_rst,
    input  logic [W-1:0] rise,
    input  logic         rd_req,
    input  logic         clr_req,
    output logic [W-1:0] hist_q,
    output logic [W-1:0] rd_data,
    output logic         rd_valid
);
    logic [W-1:0] hist_nxt;

    always_comb begin
        hist_nxt = (clr_req ? '0 : hist_q) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q   <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else if (feat_rst) begin
            hist_q   <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            hist_q   <= hist_nxt;
            rd_valid <= rd_req | clr_req;
            if (rd_req | clr_req) rd_data <= hist_q;
        end
    end

endmodule

// File: rtl/edge_irq_fsm.sv
module edge_irq_fsm
    import edge_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic feat_rst,
    input  logic arm_req,
    input  logic clr_req,
    input  logic any_rise,
    output logic irq,
    output logic armed
);
    irq_state_e state_q, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state_q <= ST_IDLE;
        else if (feat_rst) state_q <= ST_IDLE;
        else               state_q <= state_nxt;
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:   if (arm_req)  state_nxt = ST_ARMED;
            ST_ARMED:  if (any_rise) state_nxt = ST_POSTED;
            ST_POSTED: if (clr_req && !any_rise) state_nxt = ST_ARMED;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        irq   = 1'b0;
        armed = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ARMED:  armed = 1'b1;
            ST_POSTED: begin
                armed = 1'b1;
                irq   = 1'b1;
            end
            default:   ;
        endcase
    end

endmodule

// File: rtl/edge_irq_latch.sv
module edge_irq_latch
    import edge_irq_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             feat_rst,
    input  logic [WIDTH-1:0] din,
    input  logic [1:0]       cmd_op,
    output logic [WIDTH-1:0] hist_rd_data,
    output logic             rd_valid,
    output logic [WIDTH-1:0] live_lvl,
    output logic             irq
);
    logic [WIDTH-1:0] rise;
    logic [WIDTH-1:0] hist_q;
    logic             rd_req, clr_req, arm_req;
    logic             armed;

    always_comb begin
        rd_req  = 1'b0;
        clr_req = 1'b0;
        arm_req = 1'b0;
        unique case (op_e'(cmd_op))
            OP_NONE:  ;
            OP_READ:  rd_req  = 1'b1;
            OP_RDCLR: clr_req = 1'b1;
            OP_ARM:   arm_req = 1'b1;
            default:  ;
        endcase
    end

    edge_irq_sync #(.W(WIDTH), .SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (din),
        .lvl  (live_lvl),
        .rise (rise)
    );

    edge_irq_hist #(.W(WIDTH)) hist_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .feat_rst(feat_rst),
        .rise    (rise),
        .rd_req  (rd_req),
        .clr_req (clr_req),
        .hist_q  (hist_q),
        .rd_data (hist_rd_data),
        .rd_valid(rd_valid)
    );

    edge_irq_fsm fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .feat_rst(feat_rst),
        .arm_req (arm_req),
        .clr_req (clr_req),
        .any_rise(|rise),
        .irq     (irq),
        .armed   (armed)
    );

endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk
    import edge_irq_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         feat_rst,
    input logic [1:0]   cmd_op,
    input logic [W-1:0] rise,
    input logic [W-1:0] hist_q,
    input logic [W-1:0] rd_data,
    input logic         rd_valid,
    input logic         irq,
    input logic         armed
);
    logic is_clr, is_rd;
    assign is_clr = (cmd_op == OP_RDCLR);
    assign is_rd  = (cmd_op == OP_READ);

    a_r3_history_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_clr && !feat_rst) |=> ((hist_q & $past(hist_q)) == $past(hist_q)));

    a_r4_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
        ((is_rd || is_clr) && !feat_rst) |=> (rd_valid && rd_data == $past(hist_q)));

    a_r6_clear_keeps_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (is_clr && !feat_rst) |=> (hist_q == $past(rise)));

    a_r7_irq_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(armed));

    a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !is_clr && !feat_rst) |=> irq);

    a_r9_clear_with_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && is_clr && (|rise) && !feat_rst) |=> irq);

    a_r10_feature_reset: assert property (@(posedge clk) disable iff (!rst_n)
        feat_rst |=> (!irq && !armed && hist_q == '0 && !rd_valid));

endmodule

bind edge_irq_latch edge_irq_chk #(.W(WIDTH)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .feat_rst(feat_rst),
    .cmd_op  (cmd_op),
    .rise    (rise),
    .hist_q  (hist_q),
    .rd_data (hist_rd_data),
    .rd_valid(rd_valid),
    .irq     (irq),
    .armed   (armed)
);

// File: tb/edge_irq_latch_tb_top.sv
module edge_irq_latch_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         feat_rst = 1'b0;
    logic [W-1:0] din = '0;
    logic [1:0]   cmd_op = 2'b00;
    logic [W-1:0] hist_rd_data;
    logic         rd_valid;
    logic [W-1:0] live_lvl;
    logic         irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model of the requirements
    logic [W-1:0] m_s1 = '0, m_s2 = '0, m_s3 = '0, m_h = '0, m_rd = '0;
    logic         m_rv = 1'b0;
    int           m_st = 0;   // 0 unarmed, 1 armed, 2 posted
    string        tag = "R1";

    always #4 clk = ~clk;

    edge_irq_latch #(.WIDTH(W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .feat_rst    (feat_rst),
        .din         (din),
        .cmd_op      (cmd_op),
        .hist_rd_data(hist_rd_data),
        .rd_valid    (rd_valid),
        .live_lvl    (live_lvl),
        .irq         (irq)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int next_state(input int st, input logic [1:0] op, input logic any_e);
        int n = st;
        case (st)
            0: if (op == 2'b11) n = 1;
            1: if (any_e) n = 2;
            2: if (op == 2'b10 && !any_e) n = 1;
            default: n = 0;
        endcase
        return n;
    endfunction

    task automatic compare_all();
        check(live_lvl == m_s2, "R2 live level", live_lvl, m_s2);
        check(irq == (m_st == 2), {tag, " irq"}, W'(irq), W'(m_st == 2));
        check(rd_valid == m_rv, {tag, " rd_valid"}, W'(rd_valid), W'(m_rv));
        if (m_rv) check(hist_rd_data == m_rd, {tag, " read data"}, hist_rd_data, m_rd);
    endtask

    task automatic step(input logic [W-1:0] d, input logic [1:0] op, input logic f);
        logic [W-1:0] e;
        din = d; cmd_op = op; feat_rst = f;
        e = m_s2 & ~m_s3;
        if (f) begin
            m_h = '0; m_rd = '0; m_rv = 1'b0; m_st = 0;
        end else begin
            m_rv = (op == 2'b01) || (op == 2'b10);
            if (m_rv) m_rd = m_h;
            m_h  = ((op == 2'b10) ? '0 : m_h) | e;
            m_st = next_state(m_st, op, |e);
        end
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = d;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(din, 2'b00, 1'b0);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        compare_all();
        check(hist_rd_data == '0, "R1 reset data", hist_rd_data, '0);

        // R3: first rise recorded, fall and re-rise leave it unchanged
        tag = "R3"; step(16'h0001, 2'b00, 1'b0); idle(3);
        step(16'h0000, 2'b00, 1'b0); idle(3);
        step(16'h0001, 2'b00, 1'b0); idle(3);
        tag = "R4"; step(din, 2'b01, 1'b0); idle(1);
        step(din, 2'b01, 1'b0); idle(1);
        // R5: clearing read returns pre-clear value then empties
        tag = "R5"; step(din, 2'b10, 1'b0); step(din, 2'b01, 1'b0); idle(1);
        // R6: edge on the clear cycle is kept
        tag = "R6"; step(16'h0003, 2'b00, 1'b0); step(din, 2'b00, 1'b0);
        step(din, 2'b10, 1'b0); step(din, 2'b01, 1'b0); idle(1);
        // R7: arm then an edge raises irq
        tag = "R7"; step(din, 2'b11, 1'b0); idle(1);
        step(16'h0007, 2'b00, 1'b0); idle(3);
        // R8: plain read and re-arm keep irq; clearing read drops; next edge reposts
        tag = "R8"; step(din, 2'b01, 1'b0); step(din, 2'b11, 1'b0); idle(1);
        step(din, 2'b10, 1'b0); idle(1);
        step(16'h000f, 2'b00, 1'b0); idle(3);
        // R9: clearing read coinciding with an edge while posted
        tag = "R9"; step(16'h001f, 2'b00, 1'b0); step(din, 2'b00, 1'b0);
        step(din, 2'b10, 1'b0); idle(2);
        // R10: feature reset
        tag = "R10"; step(din, 2'b00, 1'b1); idle(1);
        step(din, 2'b01, 1'b0); idle(1);
        step(16'h003f, 2'b00, 1'b0); idle(3);

        // constrained random phase
        for (int c = 0; c < 4000; c++) begin
            logic [W-1:0] d;
            logic [1:0]   op;
            int           r;
            d = din;
            for (int b = 0; b < W; b++) if ($urandom_range(0, 15) == 0) d[b] = ~d[b];
            r = $urandom_range(0, 99);
            op = (r < 65) ? 2'b00 : (r < 77) ? 2'b01 : (r < 90) ? 2'b10 : 2'b11;
            case (op)
                2'b01: tag = "R4";
                2'b10: tag = "R5";
                2'b11: tag = "R7";
                default: tag = "R8";
            endcase
            step(d, op, ($urandom_range(0, 199) == 0));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule